// File: doc/BRIEF.md
# Ready/Valid Stream Handshake Monitor

This block watches one point-to-point ready/valid link inside a single clock domain and reports whether the two ends obey the handshake rules. It never drives the link. It only samples the payload, the valid and the ready signals. It counts every completed transfer. When an end breaks a rule, it raises a sticky flag for that rule and records a code for the first violation it saw.

Two build parameters describe links where one side is tied to constant one. The first covers a transmitter that produces data on every cycle. The second covers a receiver that never applies backpressure. These parameters change which rules apply. A tied valid may stay high through reset, and a tied signal that reads zero is itself a violation.

The monitor is meant to be placed next to an existing link in a larger design. Its outputs can be observed in simulation or sent to a debug status path. A single clear pulse resets the error log. Reset clears the transfer counter and the rule history, but it does not clear the error log, so a violation that occurs during reset stays visible afterwards.

Top module: `stream_link_monitor`

## Requirements
- R1: `xferCount` is zero after any clock edge taken with `rst` high. Outside reset it advances by one on exactly those edges where `linkValid` and `linkReady` are both high.
- R2: `xferCount` is `CNT_W` bits wide and wraps from its maximum value to zero.
- R3: If valid was high without a transfer on one edge, and valid is low on the next edge, the monitor raises flag bit 0. The code for this rule is 1.
- R4: If valid was high without a transfer on one edge, valid is high on the next edge and the payload differs, the monitor raises flag bit 1. The code for this rule is 2.
- R5: With `VALID_TIED` clear, valid high on an edge taken with `rst` high raises flag bit 2. The code for this rule is 3.
- R6: Lowering ready raises no flag, whether or not a transfer happened. Raising ready in the same cycle that valid rises is also legal and raises no flag.
- R7: With `READY_TIED` set, ready low on any edge raises flag bit 3. The code for this rule is 4.
- R8: With `VALID_TIED` set, valid low on an edge outside reset raises flag bit 4. The code for this rule is 5. In this mode, valid high during reset raises no flag.
- R9: The monitor raises flag bit 5 in one case. Valid is high on an edge after an edge where valid was low and ready was high, and ready was low on the edge before that. The code for this rule is 6.
- R10: Flags stay set until an edge taken with `clrErr` high. That edge sets `errFlags` and `firstErrCode` to zero, and clearing takes precedence over a violation on the same edge. `firstErrCode` (0 means none) holds the first code seen and is not overwritten later. When several rules fire on the same edge, the lowest code is kept.
- R11: The hold checks (R3, R4, R9) need history from edges taken after reset was released. A beat that was pending before reset produces no flag after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset of the link |
| clrErr | input | 1 | Clears the error flags and the first-error code |
| linkValid | input | 1 | Observed transmitter valid |
| linkReady | input | 1 | Observed receiver ready |
| linkPayload | input | PAYLOAD_W | Observed payload |
| xferCount | output | CNT_W | Count of completed transfers, wraps |
| errFlags | output | 6 | One sticky flag per rule, bit i is code i+1 |
| firstErrCode | output | 3 | Code of the first recorded violation, 0 if none |
| errAny | output | 1 | High when any flag is set |

## Verification
Two rule checks can fire on the same edge: the payload-hold check and the ready tie-off check. The bench provokes this on an instance built with both tie-offs. A clear pulse is applied on the same edge that a beat is left pending with ready low. On the next edge ready stays low and the payload changes. The result passes only if both flags are set and the recorded code is the lower one, 2. The bench also runs a separate case where a transfer and a wait-for-ready violation land on the same edge. It checks that the counter advances and that the flag is raised.

// File: rtl/stream_mon_pkg.sv
package stream_mon_pkg;
  localparam int NUM_RULES = 6;
  localparam int CODE_W = $clog2(NUM_RULES + 1);

  localparam int IDX_WITHDRAW = 0;
  localparam int IDX_UNSTABLE = 1;
  localparam int IDX_RSTVALID = 2;
  localparam int IDX_RDYTIE   = 3;
  localparam int IDX_VLDTIE   = 4;
  localparam int IDX_WAITRDY  = 5;

  typedef struct packed {
    logic                 xfer;
    logic [NUM_RULES-1:0] viol;
  } mon_strobes_t;
endpackage

// File: rtl/stream_mon_rules.sv
module stream_mon_rules
  import stream_mon_pkg::*;
#(
  parameter int PAYLOAD_W  = 8,
  parameter bit VALID_TIED = 1'b0,
  parameter bit READY_TIED = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 linkValid,
  input  logic                 linkReady,
  input  logic [PAYLOAD_W-1:0] linkPayload,
  output mon_strobes_t         strobes
);
  logic                 prevValid;
  logic                 prevReady;
  logic                 prevReady2;
  logic [PAYLOAD_W-1:0] prevPayload;
  logic                 arm1;
  logic                 arm2;
  logic                 beatPending;

  // History of the link, rebuilt from scratch after every reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      prevValid   <= 1'b0;
      prevReady   <= 1'b0;
      prevReady2  <= 1'b0;
      prevPayload <= '0;
      arm1        <= 1'b0;
      arm2        <= 1'b0;
    end else begin
      prevValid   <= linkValid;
      prevReady   <= linkReady;
      prevReady2  <= prevReady;
      prevPayload <= linkPayload;
      arm1        <= 1'b1;
      arm2        <= arm1;
    end
  end

  assign beatPending = arm1 & prevValid & ~prevReady;

  always_comb begin
    strobes.xfer = ~rst & linkValid & linkReady;
    strobes.viol[IDX_WITHDRAW] = ~rst & beatPending & ~linkValid;
    strobes.viol[IDX_UNSTABLE] = ~rst & beatPending & linkValid
                                 & (linkPayload != prevPayload);
    strobes.viol[IDX_WAITRDY]  = ~rst & arm2 & ~prevReady2 & prevReady
                                 & ~prevValid & linkValid;
  end

  generate
    if (VALID_TIED) begin : g_validTied
      always_comb begin
        strobes.viol[IDX_RSTVALID] = 1'b0;
        strobes.viol[IDX_VLDTIE]   = ~rst & ~linkValid;
      end
    end else begin : g_validFree
      always_comb begin
        strobes.viol[IDX_RSTVALID] = rst & linkValid;
        strobes.viol[IDX_VLDTIE]   = 1'b0;
      end
    end
    if (READY_TIED) begin : g_readyTied
      always_comb strobes.viol[IDX_RDYTIE] = ~linkReady;
    end else begin : g_readyFree
      always_comb strobes.viol[IDX_RDYTIE] = 1'b0;
    end
  endgenerate

  // R3: a withdrawal is only reported when valid was high on the edge before
  a_r3_withdraw_after_valid: assert property (@(posedge clk) disable iff (rst)
    strobes.viol[IDX_WITHDRAW] |-> ($past(linkValid) && !$past(linkReady) && !linkValid));

  // R6: dropping ready never produces a hold violation
  a_r6_ready_drop_legal: assert property (@(posedge clk) disable iff (rst)
    $fell(linkReady) |-> !(strobes.viol[IDX_WITHDRAW] || strobes.viol[IDX_UNSTABLE]));

  // R9: wait-for-ready only after a ready that was high while valid was low
  a_r9_wait_shape: assert property (@(posedge clk) disable iff (rst)
    strobes.viol[IDX_WAITRDY] |-> ($past(linkReady) && !$past(linkValid) && linkValid));
endmodule

// File: rtl/stream_mon_log.sv
module stream_mon_log
  import stream_mon_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clrErr,
  input  mon_strobes_t         strobes,
  output logic [CNT_W-1:0]     xferCount,
  output logic [NUM_RULES-1:0] errFlags,
  output logic [CODE_W-1:0]    firstErrCode
);
  logic [CODE_W-1:0] lowCode;

  always_ff @(posedge clk) begin
    if (rst)               xferCount <= '0;
    else if (strobes.xfer) xferCount <= xferCount + CNT_W'(1);
  end

  // Lowest set rule wins when several fire together.
  always_comb begin
    lowCode = '0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (strobes.viol[i]) lowCode = CODE_W'(i + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (clrErr) begin
      errFlags     <= '0;
      firstErrCode <= '0;
    end else begin
      errFlags <= errFlags | strobes.viol;
      if (firstErrCode == '0) firstErrCode <= lowCode;
    end
  end

  // R10: flags are never lost without a clear
  a_r10_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    !clrErr |=> ((errFlags & $past(errFlags)) == $past(errFlags)));

  // R10: a recorded code survives later violations
  a_r10_code_kept: assert property (@(posedge clk) disable iff (rst)
    (!clrErr && firstErrCode != '0) |=> (firstErrCode == $past(firstErrCode)));

  // R10: clear empties the log
  a_r10_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clrErr |=> (errFlags == '0 && firstErrCode == '0));
endmodule

// File: rtl/stream_link_monitor.sv
module stream_link_monitor
  import stream_mon_pkg::*;
#(
  parameter int PAYLOAD_W  = 8,
  parameter int CNT_W      = 32,
  parameter bit VALID_TIED = 1'b0,
  parameter bit READY_TIED = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clrErr,
  input  logic                 linkValid,
  input  logic                 linkReady,
  input  logic [PAYLOAD_W-1:0] linkPayload,
  output logic [CNT_W-1:0]     xferCount,
  output logic [NUM_RULES-1:0] errFlags,
  output logic [CODE_W-1:0]    firstErrCode,
  output logic                 errAny
);
  mon_strobes_t strobes;

  stream_mon_rules #(
    .PAYLOAD_W (PAYLOAD_W),
    .VALID_TIED(VALID_TIED),
    .READY_TIED(READY_TIED)
  ) rules_i (
    .clk        (clk),
    .rst        (rst),
    .linkValid  (linkValid),
    .linkReady  (linkReady),
    .linkPayload(linkPayload),
    .strobes    (strobes)
  );

  stream_mon_log #(
    .CNT_W(CNT_W)
  ) log_i (
    .clk         (clk),
    .rst         (rst),
    .clrErr      (clrErr),
    .strobes     (strobes),
    .xferCount   (xferCount),
    .errFlags    (errFlags),
    .firstErrCode(firstErrCode)
  );

  assign errAny = |errFlags;

  // R1: the counter follows the handshake seen at the ports
  a_r1_count_on_xfer: assert property (@(posedge clk) disable iff (rst)
    (linkValid && linkReady) |=> (xferCount == $past(xferCount) + CNT_W'(1)));
  a_r1_count_idle: assert property (@(posedge clk) disable iff (rst)
    !(linkValid && linkReady) |=> $stable(xferCount));

  // R5: valid under reset without a tie-off is logged
  a_r5_valid_in_reset: assert property (@(posedge clk) disable iff (clrErr)
    (!VALID_TIED && rst && linkValid) |=> errFlags[IDX_RSTVALID]);

  // R7: a tied ready reading zero is logged
  a_r7_ready_tie: assert property (@(posedge clk) disable iff (clrErr)
    (READY_TIED && !linkReady) |=> errFlags[IDX_RDYTIE]);
endmodule

// File: tb/stream_link_monitor_tb.sv
`timescale 1ns/1ps
module stream_link_monitor_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clrErr = 1'b1;
  logic mv = 1'b0, mr = 1'b0;
  logic [7:0] mp = '0;
  logic tv = 1'b1, tr = 1'b1;
  logic [7:0] tp = '0;

  logic [31:0] mCount;
  logic [5:0]  mFlags;
  logic [2:0]  mCode;
  logic        mAny;
  logic [3:0]  tCount;
  logic [5:0]  tFlags;
  logic [2:0]  tCode;
  logic        tAny;

  int testsRun = 0;
  int failCount = 0;
  int expCnt = 0;
  int expTCnt = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic        sel;
    logic [31:0] cnt;
    logic [5:0]  flags;
    logic [2:0]  code;
  } exp_t;
  exp_t  expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  stream_link_monitor dut_i (
    .clk(clk), .rst(rst), .clrErr(clrErr),
    .linkValid(mv), .linkReady(mr), .linkPayload(mp),
    .xferCount(mCount), .errFlags(mFlags), .firstErrCode(mCode), .errAny(mAny)
  );

  stream_link_monitor #(
    .PAYLOAD_W(8), .CNT_W(4), .VALID_TIED(1'b1), .READY_TIED(1'b1)
  ) dut_t (
    .clk(clk), .rst(rst), .clrErr(clrErr),
    .linkValid(tv), .linkReady(tr), .linkPayload(tp),
    .xferCount(tCount), .errFlags(tFlags), .firstErrCode(tCode), .errAny(tAny)
  );

  // One link cycle on the main instance; models the counters per R1/R2.
  task automatic drive(input logic v, input logic r, input logic [7:0] p);
    mv = v; mr = r; mp = p;
    @(posedge clk);
    if (rst) begin
      expCnt = 0;
      expTCnt = 0;
    end else begin
      if (v && r) expCnt++;
      if (tv && tr) expTCnt = (expTCnt + 1) % 16;
    end
    @(negedge clk);
  endtask

  task automatic expectMain(input string tag, input logic [5:0] f, input logic [2:0] c);
    expQ.push_back('{sel: 1'b0, cnt: 32'(expCnt), flags: f, code: c});
    tagQ.push_back(tag);
  endtask

  task automatic expectTied(input string tag, input logic [5:0] f, input logic [2:0] c);
    expQ.push_back('{sel: 1'b1, cnt: 32'(expTCnt), flags: f, code: c});
    tagQ.push_back(tag);
  endtask

  task automatic clearCycle();
    clrErr = 1'b1;
    drive(1'b0, 1'b0, 8'h00);
    clrErr = 1'b0;
  endtask

  // Scoreboard monitor: pops expected items and compares with the ports.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (expQ.size() > 0) begin
        exp_t e;
        string t;
        logic [31:0] aCnt;
        logic [5:0]  aFlags;
        logic [2:0]  aCode;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        aCnt   = e.sel ? {28'd0, tCount} : mCount;
        aFlags = e.sel ? tFlags : mFlags;
        aCode  = e.sel ? tCode : mCode;
        testsRun++;
        if (aCnt !== e.cnt || aFlags !== e.flags || aCode !== e.code) begin
          failCount++;
          $display("FAIL %s: actual cnt=%0d flags=%b code=%0d expected cnt=%0d flags=%b code=%0d",
                   t, aCnt, aFlags, aCode, e.cnt, e.flags, e.code);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failCount++;
      testsRun++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, failCount);
      $finish;
    end
  end

  initial begin
    // Reset with clear; tied instance holds valid high in reset (R8).
    repeat (3) drive(1'b0, 1'b0, 8'h00);
    rst = 1'b0;
    clrErr = 1'b0;
    drive(1'b0, 1'b0, 8'h00);
    expectMain("R1 reset state", 6'b000000, 3'd0);
    expectTied("R8 tied valid high in reset is legal", 6'b000000, 3'd0);

    // R1 and R6: transfers, ready drops, ready rising together with valid
    drive(1'b1, 1'b0, 8'hA5);
    drive(1'b1, 1'b1, 8'hA5);
    drive(1'b0, 1'b1, 8'h00);
    drive(1'b0, 1'b0, 8'h00);
    drive(1'b1, 1'b1, 8'h3C);
    drive(1'b1, 1'b0, 8'h11);
    drive(1'b1, 1'b0, 8'h11);
    drive(1'b1, 1'b1, 8'h11);
    drive(1'b0, 1'b0, 8'h00);
    expectMain("R1 R6 legal traffic counted, no flags", 6'b000000, 3'd0);

    // R3: valid withdrawn before transfer
    drive(1'b1, 1'b0, 8'h55);
    drive(1'b0, 1'b0, 8'h55);
    expectMain("R3 valid withdrawn", 6'b000001, 3'd1);

    // R4 and R10: payload changed while held; first code stays 1
    drive(1'b1, 1'b0, 8'h66);
    drive(1'b1, 1'b0, 8'h67);
    expectMain("R4 payload unstable, R10 first code kept", 6'b000011, 3'd1);
    drive(1'b1, 1'b1, 8'h67);
    drive(1'b0, 1'b0, 8'h00);
    expectMain("R10 flags sticky after transfer", 6'b000011, 3'd1);

    clearCycle();
    expectMain("R10 clear empties log", 6'b000000, 3'd0);

    // R9: valid rises on the cycle after ready rose; transfer on the same edge
    drive(1'b0, 1'b0, 8'h00);
    drive(1'b0, 1'b1, 8'h00);
    drive(1'b1, 1'b1, 8'h77);
    expectMain("R9 wait for ready with transfer on same edge", 6'b100000, 3'd6);
    drive(1'b0, 1'b0, 8'h00);

    clearCycle();

    // R5 and R11: pending beat then reset with valid high
    drive(1'b1, 1'b0, 8'h88);
    rst = 1'b1;
    drive(1'b1, 1'b0, 8'h88);
    drive(1'b1, 1'b0, 8'h88);
    rst = 1'b0;
    drive(1'b0, 1'b0, 8'h00);
    drive(1'b0, 1'b0, 8'h00);
    expectMain("R5 valid in reset, R11 no carry-over, R1 count cleared", 6'b000100, 3'd3);

    // R10: clear wins over a violation on the same edge
    clearCycle();
    drive(1'b1, 1'b0, 8'h01);
    clrErr = 1'b1;
    drive(1'b0, 1'b0, 8'h00);
    clrErr = 1'b0;
    expectMain("R10 clear takes precedence", 6'b000000, 3'd0);
    drive(1'b0, 1'b0, 8'h00);
    expectMain("R10 log stays empty after clear", 6'b000000, 3'd0);

    // R2: tied instance transfers every cycle, 4-bit counter wraps
    clearCycle();
    repeat (17) drive(1'b0, 1'b0, 8'h00);
    expectTied("R2 counter wraps", 6'b000000, 3'd0);

    // R4 with R7 on the same edge: lowest code recorded
    tr = 1'b0;
    tp = 8'h10;
    clrErr = 1'b1;
    drive(1'b0, 1'b0, 8'h00);
    clrErr = 1'b0;
    tp = 8'h11;
    drive(1'b0, 1'b0, 8'h00);
    expectTied("R4 R7 same edge, lower code kept", 6'b001010, 3'd2);
    tr = 1'b1;
    drive(1'b0, 1'b0, 8'h00);
    expectMain("R6 main idle untouched", 6'b000000, 3'd0);

    // R8: tied valid reading zero outside reset
    clearCycle();
    tv = 1'b0;
    drive(1'b0, 1'b0, 8'h00);
    expectTied("R8 valid tie-off broken", 6'b010000, 3'd5);
    tv = 1'b1;
    drive(1'b0, 1'b0, 8'h00);

    @(negedge clk);
    #5;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, failCount);
    $finish;
  end
endmodule